// File: doc/BRIEF.md
# Serial Configuration Port with Power-Mode Decode

This block receives configuration words over a write-only three-line serial link: a data line, a shift clock and an active-low frame enable. While the enable is low, each rising shift-clock edge moves one data bit into a frame register. Only the newest 17 bits are kept. When the enable returns high, the last four bits of the frame are read as an address and the leading 13 bits as a payload. The payload goes into one of three latches: a divider word, a gain/LNA word, or a mode/configuration word. Any other address, including the one reserved for test, changes nothing.

The three serial inputs are brought into the system clock through multi-stage synchronisers, and their edges are detected in that domain. Each shift-clock phase should therefore last at least a few system clocks. Before a gain code is accepted it is checked against the eighteen legal attenuation codes. An illegal code leaves the previous setting in place and sets a sticky error flag. The mode bits are combined with three level pins. From them the block derives power enables for the synthesizer, receiver, transmitter, IF synthesizer and LNA.

Top module: `ser_cfg_port`

## Requirements
- R1: After reset the divider word equals RF_PRESET (default 4800), the gain code is 6'h3F with step 0, the stored LNA bit is 1, every mode and configuration bit is 0, and the error flag is 0.
- R2: Rising shift-clock edges that arrive while the enable is high do not alter the frame register. An enable low/high pulse with no clocks in between reloads the frame that was already held.
- R3: Bits enter MSB first, and only the final 17 bits of a frame are kept. Extra leading bits are dropped without any error indication.
- R4: Address 4'b0011 (frame bits [3:0]) loads frame bits [16:4] into the 13-bit divider word.
- R5: Address 4'b0010 loads payload bit 6 as the LNA bit and payload bits [5:0] as the gain code. The step output gives the attenuation divided by 4 dB. The codes for steps 0 to 17 are 3F,3E,2F,2E,1F,1E,1D,1C,17,16,07,06,05,04,03,02,01,00 (hex).
- R6: A gain word whose code is outside that list changes neither the gain code, the step nor the LNA bit. It sets the error flag, which stays set until reset, even after later legal words.
- R7: Address 4'b1100 loads the mode word from payload bits [10:0]. Bit 0 is software TX, bit 1 software RX, bit 2 software SYN, bit 3 IF-synthesizer enable, and bits 4 to 10 drive cfg_band_hi, cfg_sb_infra, cfg_cp_half, cfg_ifdiv2, cfg_ifo7, cfg_ref130 and cfg_filt91 in that order.
- R8: Every other address, including the test address 4'b0000, leaves all latches unchanged.
- R9: The addressed latch is written once the enable rises, whatever the shift-clock level. A shift-clock rise that lands in the same system cycle as the enable rise is not shifted in.
- R10: The effective SYN, RX and TX signals are the OR of each pin and its software bit. The synthesizer enable equals effective SYN. The receiver enable is SYN and RX without TX. The transmitter enable is SYN and TX without RX.
- R11: The IF-synthesizer enable is the software IF bit OR the transmitter enable. The LNA enable is the receiver enable AND the stored LNA bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_dat | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock |
| ser_en_n | input | 1 | Frame enable, active low |
| pin_syn | input | 1 | Synthesizer mode pin |
| pin_rx | input | 1 | Receive mode pin |
| pin_tx | input | 1 | Transmit mode pin |
| rf_word | output | FRAME_W-4 | Divider word |
| gain_code | output | 6 | Accepted gain code |
| gain_step | output | 5 | Attenuation in 4 dB steps |
| gain_err | output | 1 | Sticky illegal-gain flag |
| cfg_band_hi | output | 1 | High band selected |
| cfg_sb_infra | output | 1 | Low-side LO selected |
| cfg_cp_half | output | 1 | Transmit charge pump current halved |
| cfg_ifdiv2 | output | 1 | IF divided by two |
| cfg_ifo7 | output | 1 | IF synthesizer divides by seven |
| cfg_ref130 | output | 1 | Reference divides by 130 |
| cfg_filt91 | output | 1 | Upper transmit IF filter selected |
| pwr_syn | output | 1 | Synthesizer enable |
| pwr_rx | output | 1 | Receiver enable |
| pwr_tx | output | 1 | Transmitter enable |
| pwr_ifsyn | output | 1 | IF synthesizer enable |
| pwr_lna | output | 1 | LNA enable |

## Verification
A rising shift-clock edge and the enable's rising edge can meet in the same synchronised system cycle. If both were honoured, the frame would shift one place and lose its address. The bench provokes this by raising both lines on the same system edge at the end of a divider frame. It then requires that the divider word equal the frame as it stood before that edge. The previous word was set to a different value, so a shifted frame would show up as the old word left in place.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
   localparam int ADDR_W = 4;
   localparam int MODE_W = 11;

   localparam logic [ADDR_W-1:0] ADR_TEST = 4'b0000;
   localparam logic [ADDR_W-1:0] ADR_GAIN = 4'b0010;
   localparam logic [ADDR_W-1:0] ADR_DIV  = 4'b0011;
   localparam logic [ADDR_W-1:0] ADR_MODE = 4'b1100;

   // mode word, MSB first; payload bit 0 is tx
   typedef struct packed {
      logic filt91;
      logic ref130;
      logic ifo7;
      logic ifdiv2;
      logic cp_half;
      logic sb_infra;
      logic band_hi;
      logic txifon;
      logic syn;
      logic rx;
      logic tx;
   } mode_t;

   typedef struct packed {
      logic       ok;
      logic [4:0] step;
   } gain_lu_t;

   function automatic gain_lu_t gain_lookup(input logic [5:0] c);
      gain_lu_t r;
      r.ok = 1'b1;
      case (c)
         6'h3F: r.step = 5'd0;
         6'h3E: r.step = 5'd1;
         6'h2F: r.step = 5'd2;
         6'h2E: r.step = 5'd3;
         6'h1F: r.step = 5'd4;
         6'h1E: r.step = 5'd5;
         6'h1D: r.step = 5'd6;
         6'h1C: r.step = 5'd7;
         6'h17: r.step = 5'd8;
         6'h16: r.step = 5'd9;
         6'h07: r.step = 5'd10;
         6'h06: r.step = 5'd11;
         6'h05: r.step = 5'd12;
         6'h04: r.step = 5'd13;
         6'h03: r.step = 5'd14;
         6'h02: r.step = 5'd15;
         6'h01: r.step = 5'd16;
         6'h00: r.step = 5'd17;
         default: begin
            r.ok   = 1'b0;
            r.step = 5'd0;
         end
      endcase
      return r;
   endfunction
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ser_cfg_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("ser_cfg_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {STAGES{RST_VAL}};
      else        st <= {st[STAGES-2:0], d};
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/ser_cfg_front.sv
module ser_cfg_front #(
   parameter int FRAME_W = 17
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               sen_n,
   input  logic               sdat,
   output logic [FRAME_W-1:0] frame,
   output logic               load
);
   if (FRAME_W < 2) begin : g_bad_frame
      $error("ser_cfg_front: FRAME_W must be at least 2");
   end

   logic sclk_q, sen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         sen_q  <= 1'b1;
         frame  <= '0;
         load   <= 1'b0;
      end else begin
         sclk_q <= sclk;
         sen_q  <= sen_n;
         load   <= sen_n & ~sen_q;
         if (sclk && !sclk_q && !sen_n)
            frame <= {frame[FRAME_W-2:0], sdat};
      end
   end
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
   import ser_cfg_pkg::*;
#(
   parameter int          FRAME_W    = 17,
   parameter int unsigned RF_PRESET  = 4800,
   parameter logic [5:0]  AGC_PRESET = 6'h3F,
   parameter bit          LNA_PRESET = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [FRAME_W-1:0]        frame,
   input  logic                      load,
   output logic [FRAME_W-ADDR_W-1:0] rf_word,
   output logic [5:0]                gain_code,
   output logic [4:0]                gain_step,
   output logic                      lna_on,
   output mode_t                     mode,
   output logic                      gain_err
);
   localparam int       DATA_W = FRAME_W - ADDR_W;
   localparam gain_lu_t PRE_LU = gain_lookup(AGC_PRESET);

   if (DATA_W < MODE_W) begin : g_bad_data
      $error("ser_cfg_bank: payload narrower than mode word");
   end
   if (!PRE_LU.ok) begin : g_bad_preset
      $error("ser_cfg_bank: AGC_PRESET is not a legal code");
   end

   logic [ADDR_W-1:0] adr;
   logic [DATA_W-1:0] dat;
   gain_lu_t          lu;

   assign adr = frame[ADDR_W-1:0];
   assign dat = frame[FRAME_W-1:ADDR_W];
   assign lu  = gain_lookup(dat[5:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rf_word   <= DATA_W'(RF_PRESET);
         gain_code <= AGC_PRESET;
         gain_step <= PRE_LU.step;
         lna_on    <= LNA_PRESET;
         mode      <= '0;
         gain_err  <= 1'b0;
      end else if (load) begin
         case (adr)
            ADR_DIV: rf_word <= dat;
            ADR_GAIN: begin
               if (lu.ok) begin
                  gain_code <= dat[5:0];
                  gain_step <= lu.step;
                  lna_on    <= dat[6];
               end else begin
                  gain_err  <= 1'b1;
               end
            end
            ADR_MODE: mode <= mode_t'(dat[MODE_W-1:0]);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
   import ser_cfg_pkg::*;
#(
   parameter int          FRAME_W     = 17,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned RF_PRESET   = 4800,
   parameter logic [5:0]  AGC_PRESET  = 6'h3F
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ser_dat,
   input  logic                      ser_clk,
   input  logic                      ser_en_n,
   input  logic                      pin_syn,
   input  logic                      pin_rx,
   input  logic                      pin_tx,
   output logic [FRAME_W-ADDR_W-1:0] rf_word,
   output logic [5:0]                gain_code,
   output logic [4:0]                gain_step,
   output logic                      gain_err,
   output logic                      cfg_band_hi,
   output logic                      cfg_sb_infra,
   output logic                      cfg_cp_half,
   output logic                      cfg_ifdiv2,
   output logic                      cfg_ifo7,
   output logic                      cfg_ref130,
   output logic                      cfg_filt91,
   output logic                      pwr_syn,
   output logic                      pwr_rx,
   output logic                      pwr_tx,
   output logic                      pwr_ifsyn,
   output logic                      pwr_lna
);
   localparam int DATA_W = FRAME_W - ADDR_W;

   if (DATA_W < MODE_W) begin : g_bad_frame
      $error("ser_cfg_port: FRAME_W too small for the mode word");
   end

   logic               s_en_n, s_clk, s_dat;
   logic [FRAME_W-1:0] frame;
   logic               frame_load;
   logic               lna_on;
   mode_t              mode;

   ser_cfg_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_en_n, ser_clk, ser_dat}),
      .q     ({s_en_n, s_clk, s_dat})
   );

   ser_cfg_front #(.FRAME_W(FRAME_W)) u_front (
      .clk   (clk),
      .rst_n (rst_n),
      .sclk  (s_clk),
      .sen_n (s_en_n),
      .sdat  (s_dat),
      .frame (frame),
      .load  (frame_load)
   );

   ser_cfg_bank #(
      .FRAME_W    (FRAME_W),
      .RF_PRESET  (RF_PRESET),
      .AGC_PRESET (AGC_PRESET),
      .LNA_PRESET (1'b1)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame     (frame),
      .load      (frame_load),
      .rf_word   (rf_word),
      .gain_code (gain_code),
      .gain_step (gain_step),
      .lna_on    (lna_on),
      .mode      (mode),
      .gain_err  (gain_err)
   );

   logic syn_e, rx_e, tx_e;

   always_comb begin
      syn_e     = pin_syn | mode.syn;
      rx_e      = pin_rx  | mode.rx;
      tx_e      = pin_tx  | mode.tx;
      pwr_syn   = syn_e;
      pwr_rx    = syn_e & rx_e & ~tx_e;
      pwr_tx    = syn_e & tx_e & ~rx_e;
      pwr_ifsyn = mode.txifon | pwr_tx;
      pwr_lna   = pwr_rx & lna_on;
   end

   assign cfg_band_hi  = mode.band_hi;
   assign cfg_sb_infra = mode.sb_infra;
   assign cfg_cp_half  = mode.cp_half;
   assign cfg_ifdiv2   = mode.ifdiv2;
   assign cfg_ifo7     = mode.ifo7;
   assign cfg_ref130   = mode.ref130;
   assign cfg_filt91   = mode.filt91;
endmodule

// File: rtl/ser_cfg_port_chk.sv
module ser_cfg_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_load,
   input logic [5:0] gain_code,
   input logic [6:0] cfg,
   input logic       gain_err,
   input logic       pwr_syn,
   input logic       pwr_rx,
   input logic       pwr_tx,
   input logic       pwr_ifsyn,
   input logic       pwr_lna
);
   AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_load |=> $stable(gain_code)); // R5
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_load |=> $stable(cfg)); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) gain_err |=> gain_err); // R6
   AST_RX_TX_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pwr_rx && pwr_tx)); // R10
   AST_RX_NEEDS_SYN: assert property (@(posedge clk) disable iff (!rst_n) (pwr_rx || pwr_tx) |-> pwr_syn); // R10
   AST_LNA_IN_RX: assert property (@(posedge clk) disable iff (!rst_n) pwr_lna |-> pwr_rx); // R11
   AST_IFSYN_WITH_TX: assert property (@(posedge clk) disable iff (!rst_n) pwr_tx |-> pwr_ifsyn); // R11
endmodule

bind ser_cfg_port ser_cfg_port_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_load (frame_load),
   .gain_code  (gain_code),
   .cfg        ({cfg_filt91, cfg_ref130, cfg_ifo7, cfg_ifdiv2, cfg_cp_half, cfg_sb_infra, cfg_band_hi}),
   .gain_err   (gain_err),
   .pwr_syn    (pwr_syn),
   .pwr_rx     (pwr_rx),
   .pwr_tx     (pwr_tx),
   .pwr_ifsyn  (pwr_ifsyn),
   .pwr_lna    (pwr_lna)
);

// File: tb/ser_cfg_port_test.sv
module ser_cfg_port_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic sdi = 1'b0, sck = 1'b0, sen_n = 1'b1;
   logic p_syn = 1'b0, p_rx = 1'b0, p_tx = 1'b0;
   logic [12:0] rf_word;
   logic [5:0]  gain_code;
   logic [4:0]  gain_step;
   logic gain_err, c_band, c_sb, c_cp, c_ifd, c_ifo, c_ref, c_filt;
   logic w_syn, w_rx, w_tx, w_ifs, w_lna;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   localparam logic [5:0] GC [18] = '{6'h3F, 6'h3E, 6'h2F, 6'h2E, 6'h1F, 6'h1E, 6'h1D, 6'h1C,
                                     6'h17, 6'h16, 6'h07, 6'h06, 6'h05, 6'h04, 6'h03, 6'h02,
                                     6'h01, 6'h00};

   always #2 clk = ~clk;

   ser_cfg_port uut (
      .clk(clk), .rst_n(rst_n), .ser_dat(sdi), .ser_clk(sck), .ser_en_n(sen_n),
      .pin_syn(p_syn), .pin_rx(p_rx), .pin_tx(p_tx),
      .rf_word(rf_word), .gain_code(gain_code), .gain_step(gain_step), .gain_err(gain_err),
      .cfg_band_hi(c_band), .cfg_sb_infra(c_sb), .cfg_cp_half(c_cp), .cfg_ifdiv2(c_ifd),
      .cfg_ifo7(c_ifo), .cfg_ref130(c_ref), .cfg_filt91(c_filt),
      .pwr_syn(w_syn), .pwr_rx(w_rx), .pwr_tx(w_tx), .pwr_ifsyn(w_ifs), .pwr_lna(w_lna)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] fr(input logic [12:0] d, input logic [3:0] a);
      return {15'd0, d, a};
   endfunction

   function automatic logic [31:0] cfgv();
      return 32'({c_filt, c_ref, c_ifo, c_ifd, c_cp, c_sb, c_band});
   endfunction

   function automatic logic [31:0] pwrv();
      return 32'({w_syn, w_rx, w_tx, w_ifs, w_lna});
   endfunction

   task automatic shift_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         sdi = v[i];
         tick(3);
         sck = 1'b1;
         tick(3);
         sck = 1'b0;
      end
   endtask

   task automatic send(input logic [31:0] v, input int n);
      sen_n = 1'b0;
      tick(3);
      shift_bits(v, n);
      tick(3);
      sen_n = 1'b1;
      tick(10);
   endtask

   task automatic t_reset;
      chk("R1 rf preset", 32'(rf_word), 32'd4800);
      chk("R1 gain code", 32'(gain_code), 32'h3F);
      chk("R1 gain step", 32'(gain_step), 32'd0);
      chk("R1 cfg", cfgv(), 32'd0);
      chk("R1 power", pwrv(), 32'd0);
      chk("R1 err", 32'(gain_err), 32'd0);
      p_syn = 1'b1; p_rx = 1'b1;
      tick(1);
      chk("R1 lna bit preset", pwrv(), 32'b11001);
      p_syn = 1'b0; p_rx = 1'b0;
      tick(1);
   endtask

   task automatic t_rf;
      send(fr(13'h1ABC, 4'b0011), 17);
      chk("R4 rf word", 32'(rf_word), 32'h1ABC);
      send(fr(13'h0001, 4'b0011), 17);
      chk("R4 rf word low", 32'(rf_word), 32'h0001);
   endtask

   task automatic t_long;
      send({11'd0, 4'hF, 13'h0155, 4'b0011}, 21);
      chk("R3 long frame", 32'(rf_word), 32'h0155);
   endtask

   task automatic t_gain;
      p_syn = 1'b1; p_rx = 1'b1;
      for (int s = 0; s < 18; s++) begin
         logic l;
         l = s[0];
         send(fr({6'd0, l, GC[s]}, 4'b0010), 17);
         chk("R5 gain code", 32'(gain_code), 32'(GC[s]));
         chk("R5 gain step", 32'(gain_step), 32'(s));
         chk("R5 lna", 32'(w_lna), 32'(l));
      end
   endtask

   task automatic t_gain_bad;
      send(fr({6'd0, 1'b1, GC[3]}, 4'b0010), 17);
      chk("R6 err clear before", 32'(gain_err), 32'd0);
      send(fr({6'd0, 1'b0, 6'h15}, 4'b0010), 17);
      chk("R6 code kept", 32'(gain_code), 32'h2E);
      chk("R6 step kept", 32'(gain_step), 32'd3);
      chk("R6 lna kept", 32'(w_lna), 32'd1);
      chk("R6 err set", 32'(gain_err), 32'd1);
      send(fr({6'd0, 1'b1, GC[5]}, 4'b0010), 17);
      chk("R6 later legal", 32'(gain_code), 32'h1E);
      chk("R6 err sticky", 32'(gain_err), 32'd1);
      p_syn = 1'b0; p_rx = 1'b0;
      tick(1);
   endtask

   task automatic t_mode;
      send(fr({2'b00, 7'b1010101, 4'b0110}, 4'b1100), 17);
      chk("R7 cfg A", cfgv(), 32'h55);
      chk("R10 sw syn rx", pwrv(), 32'b11001);
      send(fr({2'b11, 7'b0101010, 4'b1000}, 4'b1100), 17);
      chk("R7 cfg B", cfgv(), 32'h2A);
      chk("R11 sw ifsyn alone", pwrv(), 32'b00010);
   endtask

   task automatic t_ignore;
      send(fr(13'h1FFF, 4'b0000), 17);
      send(fr(13'h1FFF, 4'b0101), 17);
      send(fr(13'h1FFF, 4'b1111), 17);
      chk("R8 rf kept", 32'(rf_word), 32'h0155);
      chk("R8 gain kept", 32'(gain_code), 32'h1E);
      chk("R8 cfg kept", cfgv(), 32'h2A);
      chk("R8 power kept", pwrv(), 32'b00010);
   endtask

   task automatic t_idle;
      send(fr(13'h0AAA, 4'b0011), 17);
      shift_bits(fr(13'h1555, 4'b0011), 17);
      tick(3);
      sen_n = 1'b0;
      tick(4);
      sen_n = 1'b1;
      tick(10);
      chk("R2 clocks with enable high", 32'(rf_word), 32'h0AAA);
   endtask

   task automatic t_edge;
      send(fr(13'h0F0F, 4'b0011), 17);
      sen_n = 1'b0;
      tick(3);
      shift_bits(fr(13'h0777, 4'b0011), 17);
      sdi = 1'b1;
      tick(3);
      sck = 1'b1;
      sen_n = 1'b1;
      tick(10);
      chk("R9 coincident edges", 32'(rf_word), 32'h0777);
      sck = 1'b0;
      tick(4);
   endtask

   task automatic t_pins;
      logic [2:0] pc [7];
      logic [4:0] ex [7];
      pc = '{3'b000, 3'b100, 3'b110, 3'b101, 3'b010, 3'b001, 3'b111};
      ex = '{5'b00000, 5'b10000, 5'b11001, 5'b10110, 5'b00000, 5'b00000, 5'b10000};
      send(fr(13'd0, 4'b1100), 17);
      for (int k = 0; k < 7; k++) begin
         {p_syn, p_rx, p_tx} = pc[k];
         tick(1);
         chk("R10 pin decode", pwrv(), 32'(ex[k]));
      end
      send(fr({6'd0, 1'b0, 6'h3F}, 4'b0010), 17);
      {p_syn, p_rx, p_tx} = 3'b110;
      tick(1);
      chk("R11 lna off in rx", pwrv(), 32'b11000);
      {p_syn, p_rx, p_tx} = 3'b100;
      send(fr(13'b0010, 4'b1100), 17);
      chk("R10 pin or sw rx", pwrv(), 32'b11000);
      {p_syn, p_rx, p_tx} = 3'b000;
      tick(1);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_rf();
      t_long();
      t_gain();
      t_gain_bad();
      t_mode();
      t_ignore();
      t_idle();
      t_edge();
      t_pins();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule